// File: doc/BRIEF.md
# Alarm code word receiver

This block receives a serial alarm and control channel carried as one overhead bit per frame. Upstream framing logic presents each channel bit together with a one-cycle bit-valid strobe. The receiver waits for a marker made of eight consecutive ones. That marker must be followed by a byte whose first and last arriving bits are both zero. When this whole 16-bit word has arrived, the byte is captured into a holding register and a sticky pending flag is set.

A processor sees the captured byte on a read port. It clears the pending flag by pulsing a read strobe. The interrupt line is the pending flag gated by two separate controls: an interrupt enable and a link-mode select. Software clears the enable when the channel carries no useful data, for example in a line mode that has no such channel, or while alarms make the link content meaningless.

Capture depends only on the received bits. The two controls never affect which words are taken.

Top module: `alarm_word_rx`

## Requirements
- R1: A channel carrying only ones (idle) never causes a capture, never sets `rx_pend_o` and never raises `irq_o`.
- R2: A word is accepted only when the last 16 strobed bits, in arrival order, are eight ones, then a 0, then six code bits, then a 0. The captured byte has bit 0 equal to the first 0, bits 6:1 equal to the code bits in arrival order (bit 1 first), and bit 7 equal to the closing 0.
- R3: `rx_byte_o` takes the captured byte at the same rising edge that samples the closing bit. It does not change at any other time.
- R4: Every accepted word sets `rx_pend_o` at that same edge. The flag stays set until it is cleared.
- R5: `irq_o` is high exactly when `rx_pend_o`, `irq_en_i` and `link_mode_i` are all high. It follows changes of the two controls within the same cycle.
- R6: A cycle with `rd_byte_i` high clears `rx_pend_o`, and therefore `irq_o`, at the next edge. If a word completes in that same cycle, the new byte is stored and `rx_pend_o` stays set.
- R7: Words are captured whatever the values of `irq_en_i` and `link_mode_i`.
- R8: After a capture, no further capture happens until at least 16 more bits have been strobed. Words sent back to back with no gap are each captured.
- R9: A word that arrives while the previous one is unread overwrites `rx_byte_o`, and `rx_pend_o` stays high.
- R10: When `rst_n` goes low, `rx_byte_o`, `rx_pend_o` and `irq_o` clear at once and the bit history is emptied. Release takes effect through a two-stage synchronizer.
- R11: Values on `ch_bit_i` while `ch_vld_i` is low are ignored: they cause no capture and do not alter the stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ch_bit_i | input | 1 | Channel bit |
| ch_vld_i | input | 1 | One-cycle strobe marking `ch_bit_i` as a new channel bit |
| link_mode_i | input | 1 | Link-mode select; one of the two interrupt gates |
| irq_en_i | input | 1 | Interrupt enable; the other interrupt gate |
| rd_byte_i | input | 1 | Processor read of the byte register; clears the pending flag |
| rx_byte_o | output | 8 | Last captured message byte |
| rx_pend_o | output | 1 | Sticky flag: an unread byte is waiting |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The byte and the pending flag change at the rising edge that samples the closing bit of a word. There is no extra pipeline stage. A read strobe takes effect at the rising edge at which it is sampled. The interrupt line follows the pending flag and both controls with no register in between. The bench drives every input on a falling edge and compares all three outputs on the following falling edge, after exactly one rising edge. Its expectation comes from a bit-history model updated at that rising edge. The asynchronous clear is checked one nanosecond after reset falls, before any clock edge.

// File: rtl/awr_pkg.sv
package awr_pkg;
  localparam int AWR_FLAG_LEN = 8;
  localparam int AWR_BYTE_LEN = 8;
  localparam int AWR_SYNC_STAGES = 2;
endpackage

// File: rtl/awr_rst_sync.sv
module awr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/awr_window.sv
module awr_window #(
  parameter int FLAG_LEN = 8,
  parameter int BYTE_LEN = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_i,
  input  logic                vld_i,
  output logic                hit_o,
  output logic [BYTE_LEN-1:0] code_o
);
  localparam int WIN = FLAG_LEN + BYTE_LEN;

  logic [WIN-1:0] win_q;
  logic [WIN-1:0] win_d;
  logic           flag_ok;
  logic           open_ok;
  logic           close_ok;

  // newest bit enters at the top; oldest sits at bit 0
  always_comb begin
    win_d = win_q;
    if (vld_i) win_d = {bit_i, win_q[WIN-1:1]};
  end

  always_comb begin
    flag_ok  = &win_d[FLAG_LEN-1:0];
    open_ok  = ~win_d[FLAG_LEN];
    close_ok = ~win_d[WIN-1];
    hit_o    = vld_i & flag_ok & open_ok & close_ok;
    code_o   = win_d[WIN-1:FLAG_LEN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     win_q <= '0;
    else if (vld_i) win_q <= win_d;
  end
endmodule

// File: rtl/awr_hold.sv
module awr_hold #(
  parameter int BYTE_LEN = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit_i,
  input  logic [BYTE_LEN-1:0] code_i,
  input  logic                rd_i,
  output logic [BYTE_LEN-1:0] byte_o,
  output logic                pend_o
);
  logic [BYTE_LEN-1:0] byte_q;
  logic                pend_q;
  logic                pend_d;

  // a fresh capture wins over a read in the same cycle
  always_comb begin
    pend_d = pend_q;
    if (hit_i)     pend_d = 1'b1;
    else if (rd_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     byte_q <= '0;
    else if (hit_i) byte_q <= code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign byte_o = byte_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/awr_gate.sv
module awr_gate (
  input  logic pend_i,
  input  logic en_i,
  input  logic mode_i,
  output logic irq_o
);
  always_comb irq_o = pend_i & en_i & mode_i;
endmodule

// File: rtl/alarm_word_rx.sv
module alarm_word_rx #(
  parameter int FLAG_LEN    = awr_pkg::AWR_FLAG_LEN,
  parameter int BYTE_LEN    = awr_pkg::AWR_BYTE_LEN,
  parameter int SYNC_STAGES = awr_pkg::AWR_SYNC_STAGES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ch_bit_i,
  input  logic                ch_vld_i,
  input  logic                link_mode_i,
  input  logic                irq_en_i,
  input  logic                rd_byte_i,
  output logic [BYTE_LEN-1:0] rx_byte_o,
  output logic                rx_pend_o,
  output logic                irq_o
);
  logic                rst_sync_n;
  logic                hit;
  logic [BYTE_LEN-1:0] code;

  awr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  awr_window #(.FLAG_LEN(FLAG_LEN), .BYTE_LEN(BYTE_LEN)) u_win (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .bit_i  (ch_bit_i),
    .vld_i  (ch_vld_i),
    .hit_o  (hit),
    .code_o (code)
  );

  awr_hold #(.BYTE_LEN(BYTE_LEN)) u_hold (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .hit_i  (hit),
    .code_i (code),
    .rd_i   (rd_byte_i),
    .byte_o (rx_byte_o),
    .pend_o (rx_pend_o)
  );

  awr_gate u_gate (
    .pend_i (rx_pend_o),
    .en_i   (irq_en_i),
    .mode_i (link_mode_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/alarm_word_rx_chk.sv
module alarm_word_rx_chk #(
  parameter int FLAG_LEN = 8,
  parameter int BYTE_LEN = 8
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                ch_bit_i,
  input logic                ch_vld_i,
  input logic                link_mode_i,
  input logic                irq_en_i,
  input logic                rd_byte_i,
  input logic                hit,
  input logic [BYTE_LEN-1:0] code,
  input logic [BYTE_LEN-1:0] rx_byte_o,
  input logic                rx_pend_o,
  input logic                irq_o
);
  localparam int WIN   = FLAG_LEN + BYTE_LEN;
  localparam int CNT_W = $clog2(WIN + 1);

  // strobed bits since the last capture, saturating at the word length
  logic [CNT_W-1:0] since_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                        since_q <= '0;
    else if (hit)                           since_q <= '0;
    else if (ch_vld_i && since_q != WIN[CNT_W-1:0]) since_q <= since_q + 1'b1;
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |-> !ch_bit_i);
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |=> rx_byte_o == $past(code));
  p_set_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |=> rx_pend_o);
  p_rise_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rx_pend_o) |-> $past(hit));
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> (rx_pend_o && irq_en_i && link_mode_i));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_byte_i && !hit) |=> !rx_pend_o);
  p_fresh_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |-> since_q >= CNT_W'(WIN - 1));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |=> $stable(rx_byte_o));
  p_nostrobe_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ch_vld_i |-> !hit);
endmodule

bind alarm_word_rx alarm_word_rx_chk #(.FLAG_LEN(FLAG_LEN), .BYTE_LEN(BYTE_LEN)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .ch_bit_i    (ch_bit_i),
  .ch_vld_i    (ch_vld_i),
  .link_mode_i (link_mode_i),
  .irq_en_i    (irq_en_i),
  .rd_byte_i   (rd_byte_i),
  .hit         (hit),
  .code        (code),
  .rx_byte_o   (rx_byte_o),
  .rx_pend_o   (rx_pend_o),
  .irq_o       (irq_o)
);

// File: tb/sim_alarm_word_rx.sv
`timescale 1ns/1ps
module sim_alarm_word_rx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ch_bit, ch_vld, mode, en, rd;
  logic [7:0] rx_byte;
  logic       rx_pend, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_hist;
  logic [7:0]  m_byte;
  logic        m_pend;
  int          m_hits;

  always #4 clk = ~clk;

  alarm_word_rx u0 (
    .clk(clk), .rst_n(rst_n), .ch_bit_i(ch_bit), .ch_vld_i(ch_vld),
    .link_mode_i(mode), .irq_en_i(en), .rd_byte_i(rd),
    .rx_byte_o(rx_byte), .rx_pend_o(rx_pend), .irq_o(irq)
  );

  function automatic logic word_ok(input logic [15:0] h);
    return (h[7:0] == 8'hFF) && !h[8] && !h[15];
  endfunction

  function automatic logic [7:0] byte_of(input logic [5:0] c);
    return {1'b0, c, 1'b0};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic v, input logic b, input logic r);
    logic hit;
    ch_vld = v; ch_bit = b; rd = r;
    @(posedge clk);
    hit = 1'b0;
    if (v) begin
      m_hist = {b, m_hist[15:1]};
      hit = word_ok(m_hist);
    end
    if (hit) begin m_byte = m_hist[15:8]; m_pend = 1'b1; m_hits++; end
    else if (r) m_pend = 1'b0;
    @(negedge clk);
    chk(rx_byte == m_byte, "R3 byte", rx_byte, m_byte);
    chk(rx_pend == m_pend, "R4 pending", rx_pend, m_pend);
    chk(irq == (m_pend & en & mode), "R5 irq", irq, m_pend & en & mode);
  endtask

  task automatic send_word(input logic [5:0] c, input int gap_pct, input logic rd_last);
    logic [15:0] w;
    w = {1'b0, c, 1'b0, 8'hFF};
    for (int i = 0; i < 16; i++) begin
      while ($urandom_range(99) < gap_pct) tick(1'b0, 1'($urandom_range(1)), 1'b0);
      tick(1'b1, w[i], rd_last && (i == 15));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk(rx_byte == 8'h00 && !rx_pend && !irq, "R10 async clear", {rx_byte, rx_pend, irq}, 0);
    m_hist = '0; m_byte = '0; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    int hits0;
    logic [7:0] keep;
    void'($urandom(32'h5EED));
    ch_bit = 0; ch_vld = 0; mode = 0; en = 0; rd = 0; rst_n = 0; m_hits = 0;
    repeat (2) @(negedge clk);
    do_reset();

    // R1: idle ones, all gates open
    en = 1; mode = 1;
    repeat (40) tick(1'b1, 1'b1, 1'b0);
    chk(!rx_pend && !irq, "R1 idle", {rx_pend, irq}, 0);

    // R7 + R2: capture with both gates closed
    en = 0; mode = 0;
    send_word(6'h2A, 0, 1'b0);
    chk(rx_byte == 8'h54, "R2 mapping", rx_byte, 8'h54);
    chk(rx_pend && !irq, "R7 capture gated off", {rx_pend, irq}, 2'b10);

    // R5: each gate alone is not enough
    en = 1; #1;
    chk(!irq, "R5 enable only", irq, 0);
    en = 0; mode = 1; #1;
    chk(!irq, "R5 mode only", irq, 0);
    en = 1; #1;
    chk(irq, "R5 both", irq, 1);

    // R6: read clears
    tick(1'b0, 1'b0, 1'b1);
    chk(!rx_pend && !irq, "R6 read clear", {rx_pend, irq}, 0);

    // R2: short flag, then bad closing bit
    hits0 = m_hits;
    repeat (16) tick(1'b1, 1'b0, 1'b0);
    repeat (7) tick(1'b1, 1'b1, 1'b0);
    tick(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b1, 1'b0);
    tick(1'b1, 1'b0, 1'b0);
    repeat (8) tick(1'b1, 1'b1, 1'b0);
    tick(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) tick(1'b1, i[0], 1'b0);
    tick(1'b1, 1'b1, 1'b0);
    chk(!rx_pend && m_hits == hits0, "R2 rejects", rx_pend, 0);

    // R8 + R9: back to back, unread
    send_word(6'h01, 0, 1'b0);
    chk(rx_byte == byte_of(6'h01), "R8 first", rx_byte, byte_of(6'h01));
    send_word(6'h3E, 0, 1'b0);
    chk(rx_byte == byte_of(6'h3E) && rx_pend, "R9 overwrite", rx_byte, byte_of(6'h3E));
    chk(m_hits == hits0 + 2, "R8 both taken", m_hits, hits0 + 2);

    // R11: gaps with toggling data, then a long unstrobed stretch
    send_word(6'h15, 60, 1'b0);
    chk(rx_byte == byte_of(6'h15), "R11 gapped word", rx_byte, byte_of(6'h15));
    tick(1'b0, 1'b0, 1'b1);
    keep = rx_byte;
    for (int i = 0; i < 24; i++) tick(1'b0, (i % 9) != 8, 1'b0);
    chk(rx_byte == keep && !rx_pend, "R11 unstrobed ignored", rx_byte, keep);

    // R6: read coinciding with completion
    send_word(6'h0F, 0, 1'b0);
    send_word(6'h30, 0, 1'b1);
    chk(rx_pend && rx_byte == byte_of(6'h30), "R6 capture beats read", rx_pend, 1);

    // R10: reset mid-run
    do_reset();
    chk(rx_byte == 8'h00 && !rx_pend, "R10 after release", rx_byte, 0);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = $urandom_range(9);
      if ($urandom_range(9) == 0) begin en = 1'($urandom_range(1)); mode = 1'($urandom_range(1)); end
      if (op < 4) send_word(6'($urandom), $urandom_range(30), 1'($urandom_range(3) == 0));
      else if (op < 6) repeat ($urandom_range(20)) tick(1'b1, 1'b1, 1'($urandom_range(15) == 0));
      else repeat ($urandom_range(12)) tick(1'($urandom_range(3) != 0), 1'($urandom_range(1)), 1'($urandom_range(7) == 0));
    end
    chk(m_hits > 100, "R2 random captures", m_hits, 100);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule